// File: doc/BRIEF.md
# Video Text-Band Line Timer

This block supplies the vertical and horizontal timing for an on-screen text overlay on a composite video feed. It watches a digitised, active-low sync signal and sorts each low pulse by its length. A long pulse marks a frame and a short pulse marks a line. It counts the lines between frame marks, latches that count to tell a 60 Hz frame from a 50 Hz frame, and uses the latched count to find the scan line that starts the text band, a set distance above the bottom of the frame.

When it sees the line sync that opens the band, the block stops following line syncs and runs its own line-period counter for the seven scan lines of one character row. On each of those lines it pulses a strobe a programmable number of clocks into the line, and it gives the glyph row (0 to 6) that the overlay should draw. Because the band is timed from a single trigger, a misread or missing line sync inside the band cannot move or tear the text. A lock output shows that frame timing has been acquired. It drops, and drawing stops, when frame syncs stop arriving.

Top module: `vti_line_timer`

## Requirements
- R1: `sync_n` is active low. A low pulse lasting more than LINE_CLKS/2 clocks counts as a frame sync. A low pulse of LINE_CLKS/2 clocks or fewer counts as a line sync, so a pulse of exactly LINE_CLKS/2 clocks is a line sync.
- R2: At each frame sync that follows an earlier one, the number of lines in the finished frame is latched. That number is the frame-sync line plus every line sync seen after it. `std_50hz` becomes 1 when the latched count is at least STD_SPLIT (default 575) and 0 when it is below STD_SPLIT.
- R3: `locked` rises at the second frame sync after reset or after a loss of lock. No strobe is produced before that point.
- R4: The band starts on line number `total - 10 - row_shift`. Here `total` is the latched count, and the frame-sync line is line 1.
- R5: The band lasts seven lines, exactly LINE_CLKS clocks apart, with `glyph_row` going 0,1,...,6. Line syncs that are missing inside the band do not change this timing.
- R6: On each band line, `line_strobe` is high for exactly one clock cycle. For row r it is first high `h_offset + 1 + r*LINE_CLKS` clock edges after the first edge at which the band's opening line sync is sampled high.
- R7: If no frame sync arrives within 1.5 × latched count × LINE_CLKS clocks after the last one, `locked` falls and no strobe is produced until lock is acquired again under R3.
- R8: After reset, `locked`, `line_strobe`, `glyph_row` and `std_50hz` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_n | input | 1 | Digitised composite sync, low during sync, synchronous to clk |
| row_shift | input | SHIFT_W | Lines by which the band is moved up from its default position |
| h_offset | input | HCNT_W | Clocks from the band line start to the strobe, below LINE_CLKS |
| line_strobe | output | 1 | One-cycle pulse that starts the pixels of a band line |
| glyph_row | output | 3 | Character row being drawn, 0 to 6 |
| locked | output | 1 | Frame timing has been acquired |
| std_50hz | output | 1 | Latched standard: 1 for 50 Hz, 0 for 60 Hz |

## Verification
The assertions assume three things about the inputs. `sync_n` is already synchronous to `clk`. `h_offset` is below LINE_CLKS, so the strobe cannot fire twice in one line. `row_shift` leaves the band inside the frame. The bench drives sync one line period at a time with exactly LINE_CLKS clocks per line. It draws `h_offset`, `row_shift` and the pulse widths at random inside those limits. It holds these inputs steady across each frame, so a band is never measured against changing settings.

// File: rtl/vti_timer_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the text-band line timer.
package vti_timer_pkg;
    localparam int ROWS             = 7;   // scan lines per character row
    localparam int ROW_W            = $clog2(ROWS);
    localparam int BAND_FROM_BOTTOM = 10;  // default band start above frame end

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_LINE  = 2'd1,
        EV_FRAME = 2'd2
    } sync_ev_e;
endpackage

// File: rtl/vti_sync_sep.sv
`timescale 1ns/1ps
// Sorts active-low sync pulses into line or frame events by their width.
// Assumes sync_n is synchronous to clk. An event is reported one cycle
// after the first clock edge that samples sync_n high again.
module vti_sync_sep
    import vti_timer_pkg::*;
#(
    parameter int LINE_CLKS = 3200
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sync_n,
    output sync_ev_e ev
);
    localparam int LL_W = $clog2(LINE_CLKS + 2);
    localparam logic [LL_W-1:0] HALF_L = LL_W'(LINE_CLKS / 2);
    localparam logic [LL_W-1:0] SAT_L  = LL_W'(LINE_CLKS / 2 + 1);

    logic            sync_q;
    logic [LL_W-1:0] low_len;

    // Measure the low width and classify it when sync_n returns high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= 1'b1;
            low_len <= '0;
            ev      <= EV_NONE;
        end else begin
            sync_q <= sync_n;
            if (!sync_n)
                low_len <= (low_len == SAT_L) ? low_len : low_len + 1'b1;
            else
                low_len <= '0;
            if (!sync_q && sync_n)
                ev <= (low_len > HALF_L) ? EV_FRAME : EV_LINE;
            else
                ev <= EV_NONE;
        end
    end
endmodule

// File: rtl/vti_frame_track.sv
`timescale 1ns/1ps
// Counts lines per frame, latches the standard, keeps the lock and watchdog,
// and flags the line sync that opens the text band.
// Assumes row_shift keeps the band start above line 1.
module vti_frame_track
    import vti_timer_pkg::*;
#(
    parameter int LINE_CLKS = 3200,
    parameter int MAX_LINES = 1023,
    parameter int STD_SPLIT = 575,
    parameter int SHIFT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  sync_ev_e           ev,
    input  logic [SHIFT_W-1:0] row_shift,
    output logic               locked,
    output logic               std_50hz,
    output logic               trigger
);
    localparam int LINE_W = $clog2(MAX_LINES + 1);
    localparam int FCW    = $clog2(2 * (MAX_LINES + 1) * LINE_CLKS);
    localparam logic [LINE_W-1:0] SPLIT_L  = LINE_W'(STD_SPLIT);
    localparam logic [LINE_W-1:0] BOTTOM_L = LINE_W'(BAND_FROM_BOTTOM);
    localparam logic [LINE_W-1:0] LMAX_L   = LINE_W'(MAX_LINES);

    logic              seen_fs;
    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] total;
    logic [FCW-1:0]    frame_clk;
    logic [FCW-1:0]    period;
    logic [FCW-1:0]    limit;
    logic [LINE_W-1:0] start_line;
    logic [LINE_W-1:0] next_line;

    // Derive the watchdog limit and the band start from the latched count.
    always_comb begin
        period     = FCW'(total) * FCW'(LINE_CLKS);
        limit      = period + (period >> 1);
        start_line = total - BOTTOM_L - LINE_W'(row_shift);
        next_line  = (line_cnt == LMAX_L) ? line_cnt : line_cnt + 1'b1;
        trigger    = locked && (ev == EV_LINE) && (next_line == start_line);
    end

    // Track line count, standard, lock and frame watchdog.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_fs   <= 1'b0;
            locked    <= 1'b0;
            std_50hz  <= 1'b0;
            line_cnt  <= '0;
            total     <= '0;
            frame_clk <= '0;
        end else if (ev == EV_FRAME) begin
            line_cnt  <= LINE_W'(1);
            frame_clk <= '0;
            seen_fs   <= 1'b1;
            if (seen_fs) begin
                total    <= line_cnt;
                locked   <= 1'b1;
                std_50hz <= (line_cnt >= SPLIT_L);
            end
        end else begin
            if (ev == EV_LINE)
                line_cnt <= next_line;
            if (frame_clk != '1)
                frame_clk <= frame_clk + 1'b1;
            if (locked && frame_clk >= limit) begin
                locked  <= 1'b0;
                seen_fs <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vti_band_gen.sv
`timescale 1ns/1ps
// Free-running band timer: after one trigger it counts seven line periods
// and strobes at h_offset in each, ignoring line syncs until the band ends.
// Assumes h_offset < LINE_CLKS.
module vti_band_gen
    import vti_timer_pkg::*;
#(
    parameter int LINE_CLKS = 3200,
    parameter int HCNT_W    = $clog2(LINE_CLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              locked,
    input  logic              trigger,
    input  logic [HCNT_W-1:0] h_offset,
    output logic              line_strobe,
    output logic [ROW_W-1:0]  glyph_row
);
    localparam logic [HCNT_W-1:0] HLAST_L = HCNT_W'(LINE_CLKS - 1);
    localparam logic [ROW_W-1:0]  RLAST_L = ROW_W'(ROWS - 1);

    logic              band_on;
    logic [HCNT_W-1:0] hcnt;

    // Run the line-period counter and the row index through the band.
    always_ff @(posedge clk) begin
        if (!rst_n || !locked) begin
            band_on   <= 1'b0;
            hcnt      <= '0;
            glyph_row <= '0;
        end else if (!band_on) begin
            if (trigger) begin
                band_on   <= 1'b1;
                hcnt      <= '0;
                glyph_row <= '0;
            end
        end else if (hcnt == HLAST_L) begin
            hcnt <= '0;
            if (glyph_row == RLAST_L) begin
                band_on   <= 1'b0;
                glyph_row <= '0;
            end else begin
                glyph_row <= glyph_row + 1'b1;
            end
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // Pulse once per band line at the programmed horizontal offset.
    always_comb line_strobe = band_on && (hcnt == h_offset);
endmodule

// File: rtl/vti_line_timer.sv
`timescale 1ns/1ps
// Text-band line timer: classifies sync, locks to frames and times one
// seven-line character row for an overlay. Assumes sync_n is synchronous.
module vti_line_timer
    import vti_timer_pkg::*;
#(
    parameter int LINE_CLKS = 3200,
    parameter int MAX_LINES = 1023,
    parameter int STD_SPLIT = 575,
    parameter int SHIFT_W   = 4,
    parameter int HCNT_W    = $clog2(LINE_CLKS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_n,
    input  logic [SHIFT_W-1:0] row_shift,
    input  logic [HCNT_W-1:0]  h_offset,
    output logic               line_strobe,
    output logic [2:0]         glyph_row,
    output logic               locked,
    output logic               std_50hz
);
    sync_ev_e           ev;
    logic               trigger;
    logic [ROW_W-1:0]   row_i;

    vti_sync_sep #(.LINE_CLKS(LINE_CLKS)) u_sep (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_n (sync_n),
        .ev     (ev)
    );

    vti_frame_track #(
        .LINE_CLKS (LINE_CLKS),
        .MAX_LINES (MAX_LINES),
        .STD_SPLIT (STD_SPLIT),
        .SHIFT_W   (SHIFT_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .row_shift (row_shift),
        .locked    (locked),
        .std_50hz  (std_50hz),
        .trigger   (trigger)
    );

    vti_band_gen #(.LINE_CLKS(LINE_CLKS), .HCNT_W(HCNT_W)) u_band (
        .clk         (clk),
        .rst_n       (rst_n),
        .locked      (locked),
        .trigger     (trigger),
        .h_offset    (h_offset),
        .line_strobe (line_strobe),
        .glyph_row   (row_i)
    );

    assign glyph_row = 3'(row_i);
endmodule

// File: rtl/vti_line_timer_chk.sv
`timescale 1ns/1ps
// Port-level properties of the text-band line timer.
module vti_line_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       line_strobe,
    input logic [2:0] glyph_row,
    input logic       locked,
    input logic       std_50hz
);
    assert_strobe_needs_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_strobe |-> locked);

    assert_row_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        glyph_row <= 3'd6);

    assert_row_steps_by_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (glyph_row != $past(glyph_row)) && (glyph_row != 3'd0)
            |-> (glyph_row == $past(glyph_row) + 3'd1));

    assert_strobe_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_strobe |=> !line_strobe);

    assert_std_moves_when_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(std_50hz) |-> locked);
endmodule

bind vti_line_timer vti_line_timer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_strobe (line_strobe),
    .glyph_row   (glyph_row),
    .locked      (locked),
    .std_50hz    (std_50hz)
);

// File: tb/vti_line_timer_test.sv
`timescale 1ns/1ps
module vti_line_timer_test;
    localparam int LC = 16;
    localparam int HW = $clog2(LC);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_n = 1'b1;
    logic [3:0]    row_shift = '0;
    logic [HW-1:0] h_offset = '0;
    logic          line_strobe;
    logic [2:0]    glyph_row;
    logic          locked;
    logic          std_50hz;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int n_str = 0;
    int str_cyc [16];
    int str_row [16];
    bit done = 1'b0;

    vti_line_timer #(.LINE_CLKS(LC), .STD_SPLIT(575)) uut (
        .clk, .rst_n, .sync_n, .row_shift, .h_offset,
        .line_strobe, .glyph_row, .locked, .std_50hz
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Record every strobe with its cycle and row.
    always @(negedge clk) begin
        if (line_strobe && n_str < 16) begin
            str_cyc[n_str] = cyc;
            str_row[n_str] = int'(glyph_row);
            n_str++;
        end
    end

    function automatic int exp_start(int prev_total, int shift);
        return prev_total - 10 - shift;
    endfunction

    function automatic int exp_std(int total);
        return (total >= 575) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One line: low for 'low' clocks (none if no_sync), returns rise cycle.
    task automatic drive_line(input int low, input bit no_sync, output int rise);
        rise = -1;
        for (int i = 0; i < LC; i++) begin
            @(negedge clk);
            sync_n = (no_sync || i >= low) ? 1'b1 : 1'b0;
            if (i == low) rise = cyc;
        end
    endtask

    // A whole frame; line 1 carries the long pulse. Captures the start line rise.
    task automatic run_frame(input int lines, input int flow, input int slow,
                             input int start, input bit skip_band,
                             output int start_rise);
        int r;
        start_rise = -1;
        n_str = 0;
        for (int ln = 1; ln <= lines; ln++) begin
            bit skip = skip_band && ln > start && ln <= start + 6;
            drive_line((ln == 1) ? flow : slow, skip, r);
            if (ln == start) start_rise = r;
        end
    endtask

    task automatic check_band(input int rise, input int hoff);
        chk("R5 strobe count", n_str, 7);
        for (int r = 0; r < 7 && r < n_str; r++) begin
            chk("R4/R6 strobe cycle", str_cyc[r], rise + 2 + hoff + r * LC);
            chk("R5 glyph row", str_row[r], r);
        end
    endtask

    int rise;
    int shift;
    int hoff;

    initial begin
        void'($urandom(32'h1d5e_0a71));
        repeat (5) @(negedge clk);
        // R8: reset state
        chk("R8 locked", int'(locked), 0);
        chk("R8 strobe", int'(line_strobe), 0);
        chk("R8 row", int'(glyph_row), 0);
        chk("R8 std", int'(std_50hz), 0);
        rst_n = 1'b1;

        // F1: first frame sync only, no lock yet (R3)
        h_offset = HW'($urandom % LC);
        row_shift = 4'd0;
        run_frame(525, 9 + int'($urandom % 6), 1 + int'($urandom % 8), 0, 1'b0, rise);
        chk("R3 no strobe before lock", n_str, 0);
        chk("R3 not locked after one frame sync", int'(locked), 0);

        // F2: locked, band at 525-10
        hoff = int'($urandom % LC);
        h_offset = HW'(hoff);
        run_frame(525, 9 + int'($urandom % 6), 1 + int'($urandom % 8),
                  exp_start(525, 0), 1'b0, rise);
        chk("R3 locked", int'(locked), 1);
        check_band(rise, hoff);
        chk("R2 std 60", int'(std_50hz), exp_std(525));

        // F3: short pulses exactly half a line (R1), random shift
        shift = int'($urandom % 16);
        hoff = int'($urandom % LC);
        row_shift = 4'(shift);
        h_offset = HW'(hoff);
        run_frame(625, LC / 2 + 1, LC / 2, exp_start(525, shift), 1'b0, rise);
        check_band(rise, hoff);
        chk("R1/R2 std after 525-line frame", int'(std_50hz), exp_std(525));

        // F4: corner shift and offset, band placed from 625 count
        row_shift = 4'd15;
        h_offset = HW'(LC - 1);
        run_frame(625, 14, 1, exp_start(625, 15), 1'b0, rise);
        check_band(rise, LC - 1);
        chk("R2 std 50", int'(std_50hz), exp_std(625));

        // Frame sync stops: limit is 1.5*625*16 = 15000 clocks (R7)
        repeat (4000) @(negedge clk);
        chk("R7 still locked inside limit", int'(locked), 1);
        repeat (1500) @(negedge clk);
        chk("R7 lock lost after limit", int'(locked), 0);

        // F5: one frame sync after loss, still unlocked (R7)
        row_shift = 4'd0;
        run_frame(525, 12, 3, exp_start(625, 0), 1'b0, rise);
        chk("R7 no strobe while reacquiring", n_str, 0);
        chk("R7 not locked yet", int'(locked), 0);

        // F6: relocked; line syncs inside the band removed (R5)
        shift = int'($urandom % 16);
        hoff = int'($urandom % LC);
        row_shift = 4'(shift);
        h_offset = HW'(hoff);
        run_frame(525, 10, 2, exp_start(525, shift), 1'b1, rise);
        check_band(rise, hoff);
        chk("R3 relocked", int'(locked), 1);
        chk("R2 std back to 60", int'(std_50hz), exp_std(525));

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule